// File: doc/BRIEF.md
# Nibble Accumulator Processor Core

This block is a compact 4-bit processor core built around a single accumulator and sixteen 4-bit index registers. The index registers work in eight even/odd pairs, and each pair can hold an 8-bit nibble address. Program memory is read-only and separate from the data RAM. Each data word in both memories is one nibble.

The core has no instruction that names a data RAM address directly. A program first loads an index pair, either with a two-byte fetch-immediate or with increments. A send instruction then copies that pair into a data-address latch. Read and write transfers act on the latched location for as long as the latch keeps its value. Subroutine return addresses go into an internal three-entry stack that wraps around.

Program memory and data RAM sit outside the core and are read combinationally. An instruction is one byte: the upper nibble is the opcode and the lower nibble is a register, pair or immediate field. Jumps, calls, fetch-immediate and increment-and-skip take a second byte from the next program address.

Top module: `nib_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, pm_addr is 0, acc_out is 0 and ram_addr is 0. Reset also clears all index registers and the stack pointer.
- R2: Timing of a one-byte instruction. It executes in the cycle its opcode is on pm_data, and pm_addr then advances by one.
- R3: Timing of a two-byte instruction. It takes two cycles, and the second byte is read at the address following the opcode. Codes 0x1, 0x3, 0x8, 0x9 and 0xF, and any 0xE code other than 0xE0 or 0xE9, are one-cycle no-operations.
- R4: Fetch-immediate, encoded 0x2 with an even low nibble 2p, takes a second byte B. It writes B[7:4] to R(2p) and B[3:0] to R(2p+1).
- R5: Send, encoded 0x2 with an odd low nibble 2p+1, copies {R(2p),R(2p+1)} to ram_addr. ram_addr changes only on a send, so reloading the pair afterwards leaves it unchanged.
- R6: Load-immediate, encoded 0xDk, sets the accumulator to k.
- R7: Write-memory, encoded 0xE0, raises ram_we for that one cycle with ram_wdata equal to the accumulator. The nibble is stored at ram_addr, and the accumulator is unchanged.
- R8: Read-memory, encoded 0xE9, loads ram_rdata at the latched address into the accumulator.
- R9: Increment-and-skip, encoded 0x7r followed by byte T, increments Rr. If the result is nonzero it jumps to {upper pm_addr bits, T}. If Rr wraps to 0 it falls through to the next instruction. Plain increment is encoded 0x6r.
- R10: Jump is encoded 0x4h followed by byte T and goes to {h,T}. Call is encoded 0x5h followed by T; it pushes the address after T and goes to {h,T}.
- R11: Return, encoded 0xCk, pops the most recent stack entry into the program counter and sets the accumulator to k. Three nested calls return in order.
- R12: A fourth nested call silently overwrites the oldest stack entry, so the outermost return address is lost.
- R13: Load-register, encoded 0xAr, copies Rr to the accumulator. Exchange, encoded 0xBr, swaps the accumulator with Rr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pm_addr | output | 12 | Program memory address (program counter) |
| pm_data | input | 8 | Program memory byte at pm_addr |
| ram_addr | output | 8 | Latched data RAM nibble address |
| ram_wdata | output | 4 | Nibble to store |
| ram_we | output | 1 | Data RAM write strobe |
| ram_rdata | input | 4 | Data RAM nibble at ram_addr |
| acc_out | output | 4 | Accumulator contents |

## Verification
The assertions check several rules on every cycle:
- the reset values on the first free cycle;
- that the second byte of an instruction comes from the next address;
- that the address latch moves only after a send;
- that a write never disturbs the accumulator;
- that an increment-and-skip wrap falls through;
- that the stack pointer stays in range.

Some behaviour can only be shown by the bench's programs running end to end:
- the send-then-write sequence leaving the right nibble in RAM;
- the values that loop counts and subroutine returns produce;
- a fourth call losing the outermost return address, so the program never gets back to its main loop.

// File: rtl/nib_core.sv
module nib_core #(
  parameter int PC_W      = 12,
  parameter int STK_DEPTH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PC_W-1:0] pm_addr,
  input  logic [7:0]      pm_data,
  output logic [7:0]      ram_addr,
  output logic [3:0]      ram_wdata,
  output logic            ram_we,
  input  logic [3:0]      ram_rdata,
  output logic [3:0]      acc_out
);
  localparam int SP_W = (STK_DEPTH > 1) ? $clog2(STK_DEPTH) : 1;
  localparam logic [SP_W-1:0] SP_TOP = SP_W'(STK_DEPTH - 1);

  logic [PC_W-1:0] pc, pc_nxt, stk [STK_DEPTH];
  logic [SP_W-1:0] sp, sp_up, sp_dn;
  logic            phase;
  logic [7:0]      ir, alat;
  logic [3:0]      acc;
  logic [3:0]      rf [16];

  wire  [7:0] op   = phase ? ir : pm_data;
  wire  [3:0] opc  = op[7:4];
  wire  [3:0] fld  = op[3:0];
  wire  [7:0] arg  = pm_data;
  wire  [3:0] ev   = {fld[3:1], 1'b0};
  wire  [3:0] od   = {fld[3:1], 1'b1};
  wire  [3:0] rval = rf[fld];
  wire  [3:0] rinc = rval + 4'd1;
  wire  [PC_W-1:0] pc_inc = pc + 1'b1;

  wire two_word = (pm_data[7:4] == 4'h2 && !pm_data[0]) || pm_data[7:4] == 4'h4 ||
                  pm_data[7:4] == 4'h5 || pm_data[7:4] == 4'h7;
  wire need2 = !phase && two_word;
  wire go    = !need2;

  wire is_src = go && opc == 4'h2 && fld[0];
  wire is_isz = go && opc == 4'h7;
  wire is_wrm = go && opc == 4'hE && fld == 4'h0;
  wire is_rdm = go && opc == 4'hE && fld == 4'h9;

  assign sp_up = (sp == SP_TOP) ? '0 : sp + 1'b1;
  assign sp_dn = (sp == '0) ? SP_TOP : sp - 1'b1;

  assign pm_addr   = pc;
  assign ram_addr  = alat;
  assign ram_wdata = acc;
  assign ram_we    = is_wrm;
  assign acc_out   = acc;

  always_comb begin
    pc_nxt = pc_inc;
    if (go) begin
      case (opc)
        4'h4, 4'h5: pc_nxt = PC_W'({fld, arg});
        4'h7:       if (rinc != 4'd0) pc_nxt = {pc[PC_W-1:8], arg};
        4'hC:       pc_nxt = stk[sp_dn];
        default:    pc_nxt = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc    <= '0;
      phase <= 1'b0;
      ir    <= '0;
      acc   <= '0;
      alat  <= '0;
      sp    <= '0;
      for (int i = 0; i < 16; i++) rf[i] <= '0;
      for (int i = 0; i < STK_DEPTH; i++) stk[i] <= '0;
    end else if (need2) begin
      ir    <= pm_data;
      phase <= 1'b1;
      pc    <= pc_inc;
    end else begin
      phase <= 1'b0;
      pc    <= pc_nxt;
      case (opc)
        4'h2: if (fld[0]) alat <= {rf[ev], rf[od]};
              else begin rf[ev] <= arg[7:4]; rf[od] <= arg[3:0]; end
        4'h5: begin stk[sp] <= pc_inc; sp <= sp_up; end
        4'h6, 4'h7: rf[fld] <= rinc;
        4'hA: acc <= rval;
        4'hB: begin acc <= rval; rf[fld] <= acc; end
        4'hC: begin acc <= fld; sp <= sp_dn; end
        4'hD: acc <= fld;
        4'hE: if (fld == 4'h9) acc <= ram_rdata;
        default: ;
      endcase
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pm_addr == '0 && acc_out == 4'd0 && ram_addr == 8'd0));
  // R3
  second_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> pm_addr == PC_W'($past(pm_addr) + 1'b1));
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr != $past(ram_addr)) |-> $past(is_src));
  // R7
  write_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> $stable(acc_out));
  // R8
  read_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rdm |=> acc_out == $past(ram_rdata));
  // R9
  isz_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_isz && rinc == 4'd0) |=> pm_addr == PC_W'($past(pc) + 1'b1));
  // R12
  stack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_TOP);
endmodule

// File: tb/test_nib_core.sv
module test_nib_core;
  localparam int CLK_P = 10;
  localparam int NVEC  = 5;
  localparam logic [11:0] VEC [NVEC] = '{12'h053, 12'h00F, 12'hFF1, 12'hA5A, 12'h3C6};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] pm_addr;
  logic [7:0]  pm_data, ram_addr;
  logic [3:0]  ram_wdata, ram_rdata, acc_out;
  logic        ram_we;
  logic [7:0]  rom [256];
  logic [3:0]  ram [256];
  logic        pl_we = 1'b0;
  logic [7:0]  pl_a = '0;
  logic [3:0]  pl_d = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign pm_data   = rom[pm_addr[7:0]];
  assign ram_rdata = ram[ram_addr];
  always @(posedge clk)
    if (pl_we) ram[pl_a] <= pl_d;
    else if (ram_we) ram[ram_addr] <= ram_wdata;

  nib_core i_nib_core (.clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_data(pm_data),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .ram_rdata(ram_rdata), .acc_out(acc_out));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_rom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
  endtask

  task automatic preload(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk); pl_a = a; pl_d = d; pl_we = 1'b1;
    @(negedge clk); pl_we = 1'b0;
  endtask

  task automatic restart();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hits;
    bit seen;
    for (int i = 0; i < 256; i++) ram[i] = 4'h0;

    // R1 and R2/R3 timing: NOP, then jump 0x010 that spins on itself
    clr_rom();
    rom[0] = 8'h00; rom[1] = 8'h40; rom[2] = 8'h10; rom[8'h10] = 8'h40; rom[8'h11] = 8'h10;
    rst_n = 1'b0; run(2);
    chk("R1 pm_addr in reset", pm_addr, 0);
    chk("R1 acc in reset", acc_out, 0);
    chk("R1 ram_addr in reset", ram_addr, 0);
    chk("R1 ram_we in reset", ram_we, 0);
    rst_n = 1'b1;
    chk("R1 pm_addr after release", pm_addr, 0);
    run(1); chk("R2 one-byte advance", pm_addr, 1);
    run(1); chk("R3 second byte address", pm_addr, 2);
    run(1); chk("R10 jump target", pm_addr, 12'h010);
    run(2); chk("R10 jump to self", pm_addr, 12'h010);

    // R4 R5 R6 R7: table of {address, nibble}, pair chosen by index
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a;
      logic [3:0] d, p;
      a = VEC[v][11:4]; d = VEC[v][3:0]; p = 4'(2 * (v % 8));
      clr_rom();
      rom[0] = {4'h2, p}; rom[1] = a; rom[2] = {4'h2, p | 4'h1};
      rom[3] = {4'hD, d}; rom[4] = 8'hE0; rom[5] = 8'h40; rom[6] = 8'h05;
      restart(); run(12);
      chk("R7 RAM nibble written", ram[a], d);
      chk("R5 latched address", ram_addr, a);
      chk("R6 accumulator loaded", acc_out, d);
    end

    // R5 R8: latch survives pair reload, read uses the latched address
    clr_rom();
    rom[0] = 8'h22; rom[1] = 8'h37; rom[2] = 8'h23; rom[3] = 8'h22; rom[4] = 8'h12;
    rom[5] = 8'hE9; rom[6] = 8'h40; rom[7] = 8'h06;
    preload(8'h37, 4'h9); preload(8'h12, 4'h4);
    restart(); run(12);
    chk("R5 latch kept after pair reload", ram_addr, 8'h37);
    chk("R8 read from latched address", acc_out, 9);

    // R9 R13: loop R1 from D to wrap, counting in R2
    clr_rom();
    rom[0] = 8'h20; rom[1] = 8'h0D; rom[2] = 8'h62; rom[3] = 8'h71; rom[4] = 8'h02;
    rom[5] = 8'hA2; rom[6] = 8'h40; rom[7] = 8'h06;
    restart(); run(30);
    chk("R9 loop iterations before wrap", acc_out, 3);
    chk("R9 fell through after wrap", pm_addr >= 6 && pm_addr <= 7, 1);

    // R13: exchange and load register
    clr_rom();
    rom[0] = 8'hD5; rom[1] = 8'hB4; rom[2] = 8'hA4; rom[3] = 8'h40; rom[4] = 8'h03;
    restart();
    run(2); chk("R13 exchange gives old R4", acc_out, 0);
    run(1); chk("R13 load gives swapped value", acc_out, 5);

    // R10 R11: single call and return with immediate
    clr_rom();
    rom[0] = 8'h50; rom[1] = 8'h10; rom[2] = 8'h40; rom[3] = 8'h02; rom[8'h10] = 8'hC7;
    restart(); run(10);
    chk("R11 return immediate", acc_out, 7);
    chk("R11 returned to caller", pm_addr >= 2 && pm_addr <= 3, 1);

    // R11: three nested calls unwind in order
    clr_rom();
    rom[0] = 8'h50; rom[1] = 8'h20; rom[2] = 8'h40; rom[3] = 8'h02;
    rom[8'h20] = 8'h50; rom[8'h21] = 8'h30; rom[8'h22] = 8'hC2;
    rom[8'h30] = 8'h50; rom[8'h31] = 8'h40; rom[8'h32] = 8'hC3;
    rom[8'h40] = 8'hC4;
    restart(); run(40);
    chk("R11 three-deep final acc", acc_out, 2);
    chk("R11 three-deep back in main", pm_addr >= 2 && pm_addr <= 3, 1);

    // R12: fourth call overwrites the oldest return address
    rom[8'h40] = 8'h50; rom[8'h41] = 8'h50; rom[8'h42] = 8'hC4; rom[8'h50] = 8'hC5;
    restart();
    hits = 0; seen = 1'b0;
    for (int c = 0; c < 100; c++) begin
      run(1);
      if (pm_addr == 12'h002) seen = 1'b1;
      if (pm_addr == 12'h042) hits++;
    end
    chk("R12 main return address lost", seen, 0);
    chk("R12 overwritten entry reused", hits >= 2, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule